// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache with Flush-by-Address Invalidate

This block is a small direct-mapped write-back data cache that sits between a processor and main memory. It serves loads and stores from its line storage. On a miss it writes back a dirty victim line and then fetches the requested line. Writes allocate on a miss and mark the line dirty.

The block also accepts a flush command. Its effective address is computed upstream and driven on the ordinary access address input, while a single flush bit marks the operation. The cache checks only the line that could hold that address. If that line is present, the cache marks it invalid and drops any dirty data without writing it back. This invalidate is meant for use just before a DMA engine overwrites those memory words. The next read of the line then misses and returns the new memory contents instead of a stale cached copy.

The controller has three named states:
- `ST_IDLE` serves hits and flushes.
- `ST_WBACK` writes the victim line back to memory.
- `ST_FILL` fetches the requested line from memory.

The controller moves between them as follows:
- IDLE→WBACK: a read or write misses and the victim line is valid and dirty.
- IDLE→FILL: a read or write misses and the victim line is clean or invalid.
- WBACK→FILL: the memory handshake completes.
- FILL→IDLE: the memory handshake completes.
- IDLE→IDLE: a hit, a flush, or no operation.

Top module: `wb_cache_flush`

## Requirements
- R1: Reset marks every line invalid and clean. With no request after reset, `cpu_stall` and `mem_req` are low, and the first read misses.
- R2: A read that hits returns the addressed word on `cpu_rdata` in the same cycle, with `cpu_stall` low and no memory transaction. The address splits into tag (bits 31:8), index (bits 7:4), word (bits 3:2) and byte (bits 1:0).
- R3: A read that misses on a clean or invalid line holds `cpu_stall` high. It performs exactly one line read (`mem_we`=0) and then returns the word from the fetched line.
- R4: A write that hits updates only the addressed word and starts no memory transaction. A write that misses allocates the line first. A miss on a dirty line writes the old line back (`mem_we`=1) to the victim's own line address before the line read.
- R5: A flush whose index selects a valid line with a matching tag makes that line invalid. The next read of any word in that line misses and returns the current memory contents.
- R6: A flush of a matching dirty line drops the dirty data. No write-back happens, then or at any later eviction.
- R7: A flush whose tag does not match the indexed line, or whose line is invalid, leaves the cache contents and dirty state unchanged.
- R8: A flush completes in one cycle. It never raises `cpu_stall` and never starts a memory transaction.
- R9: When `cpu_flush` is high together with `cpu_rd` or `cpu_wr`, only the flush is carried out. The write data is discarded.
- R10: Memory handshake rules:
  - Each transaction moves one whole line; word w sits at bits [32w+31:32w] of `mem_wline` and `mem_rline`.
  - `mem_addr` is line-aligned (bits 3:0 zero).
  - While `mem_req` waits for `mem_ready`, `mem_req`, `mem_addr` and `mem_we` stay stable.
  - A transfer takes place on a clock edge where both `mem_req` and `mem_ready` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 32 | Byte address of an access or a flush |
| cpu_rd | input | 1 | Read request |
| cpu_wr | input | 1 | Write request |
| cpu_wdata | input | 32 | Write data |
| cpu_flush | input | 1 | Flush-invalidate request for `cpu_addr` |
| cpu_rdata | output | 32 | Read data |
| cpu_stall | output | 1 | Access not yet complete |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 = line write-back, 0 = line read |
| mem_addr | output | 32 | Line-aligned memory address |
| mem_wline | output | 128 | Line written back to memory |
| mem_rline | input | 128 | Line returned by memory |
| mem_ready | input | 1 | Memory accepts or returns the line on this edge |

## Verification
The assertions rely on three properties of the inputs:
- The processor holds address, request and write data stable while `cpu_stall` is high.
- `cpu_flush` is raised only in a cycle where the cache is not stalling.
- The memory raises `mem_ready` only while `mem_req` is high.

The bench drives one operation at a time from tasks that wait out the stall before changing anything. Its memory model raises ready only in answer to a pending request, after a random latency of zero to two cycles. Every flush in the random phase follows a DMA-style overwrite of the whole line, so the bench's expected memory image stays exact even when dirty data is dropped. The one directed case that raises flush together with a write exercises the priority rule deliberately.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WBACK = 2'd1,
        ST_FILL  = 2'd2
    } wbc_state_e;

endpackage

// File: rtl/wbc_tag_store.sv
module wbc_tag_store #(
    parameter int LINES = 16,
    parameter int TAG_W = 24,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic             fill_en,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             set_dirty,
    input  logic             flush_inval,
    output logic             lk_valid,
    output logic             lk_dirty,
    output logic [TAG_W-1:0] lk_tag
);

    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;
    logic [TAG_W-1:0] tag_q [LINES];

    // Valid and dirty flags: reset clears them, flush wins over fill and write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (flush_inval) begin
            valid_q[lk_idx] <= 1'b0;
            dirty_q[lk_idx] <= 1'b0;
        end else if (fill_en) begin
            valid_q[lk_idx] <= 1'b1;
            dirty_q[lk_idx] <= 1'b0;
        end else if (set_dirty) begin
            dirty_q[lk_idx] <= 1'b1;
        end
    end

    // Tag array: meaningful only while the matching valid bit is set.
    always_ff @(posedge clk) begin
        if (fill_en && !flush_inval) begin
            tag_q[lk_idx] <= fill_tag;
        end
    end

    assign lk_valid = valid_q[lk_idx];
    assign lk_dirty = dirty_q[lk_idx];
    assign lk_tag   = tag_q[lk_idx];

    AST_FLUSH_INVAL: assert property (@(posedge clk) disable iff (!rst_n) flush_inval |=> !valid_q[$past(lk_idx)] && !dirty_q[$past(lk_idx)]) else $error("flush left line valid or dirty"); // R6
    AST_FILL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n) (fill_en && !flush_inval) |=> valid_q[$past(lk_idx)] && !dirty_q[$past(lk_idx)]) else $error("fill left line invalid or dirty"); // R3

endmodule

// File: rtl/wbc_data_store.sv
module wbc_data_store #(
    parameter int LINES  = 16,
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    localparam int IDX_W  = $clog2(LINES),
    localparam int OFF_W  = $clog2(WORDS),
    localparam int LINE_W = WORDS * DATA_W
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  idx,
    input  logic [OFF_W-1:0]  off,
    input  logic              fill_en,
    input  logic [LINE_W-1:0] fill_line,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_word,
    output logic [LINE_W-1:0] rd_line
);

    // One bank per word position, so a fill writes all banks at once.
    for (genvar w = 0; w < WORDS; w++) begin : g_bank
        logic [DATA_W-1:0] bank [LINES];

        always_ff @(posedge clk) begin
            if (fill_en) begin
                bank[idx] <= fill_line[w*DATA_W +: DATA_W];
            end else if (wr_en && (off == OFF_W'(w))) begin
                bank[idx] <= wr_data;
            end
        end

        assign rd_line[w*DATA_W +: DATA_W] = bank[idx];
    end

    assign rd_word = rd_line[off*DATA_W +: DATA_W];

endmodule

// File: rtl/wbc_ctrl.sv
module wbc_ctrl
    import wbc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_rd,
    input  logic cpu_wr,
    input  logic cpu_flush,
    input  logic lk_valid,
    input  logic lk_dirty,
    input  logic tag_match,
    input  logic mem_ready,
    output logic cpu_stall,
    output logic mem_req,
    output logic mem_we,
    output logic fill_en,
    output logic wr_en,
    output logic set_dirty,
    output logic flush_inval,
    output logic victim_sel
);

    wbc_state_e state_q;
    wbc_state_e state_d;

    logic hit;
    logic access;

    assign hit    = lk_valid && tag_match;
    assign access = !cpu_flush && (cpu_rd || cpu_wr);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (access && !hit) begin
                    state_d = (lk_valid && lk_dirty) ? ST_WBACK : ST_FILL;
                end
            end
            ST_WBACK: begin
                if (mem_ready) state_d = ST_FILL;
            end
            ST_FILL: begin
                if (mem_ready) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output logic.
    always_comb begin
        cpu_stall   = 1'b0;
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        fill_en     = 1'b0;
        wr_en       = 1'b0;
        set_dirty   = 1'b0;
        flush_inval = 1'b0;
        victim_sel  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cpu_stall   = access && !hit;
                wr_en       = access && hit && cpu_wr;
                set_dirty   = access && hit && cpu_wr;
                flush_inval = cpu_flush && hit;
            end
            ST_WBACK: begin
                cpu_stall  = 1'b1;
                mem_req    = 1'b1;
                mem_we     = 1'b1;
                victim_sel = 1'b1;
            end
            ST_FILL: begin
                cpu_stall = 1'b1;
                mem_req   = 1'b1;
                fill_en   = mem_ready;
            end
            default: cpu_stall = 1'b1;
        endcase
    end

    AST_FLUSH_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n) (state_q == ST_IDLE && cpu_flush) |=> !mem_req) else $error("flush started a memory transaction"); // R8
    AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && mem_ready && mem_we) |=> (mem_req && !mem_we)) else $error("write-back not followed by fill"); // R4
    AST_FILL_DONE: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && mem_ready && !mem_we) |=> !mem_req) else $error("request held after fill"); // R3

endmodule

// File: rtl/wb_cache_flush.sv
module wb_cache_flush #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LINES  = 16,
    parameter int WORDS  = 4,
    localparam int LINE_W = WORDS * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_flush,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_stall,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LINE_W-1:0] mem_wline,
    input  logic [LINE_W-1:0] mem_rline,
    input  logic              mem_ready
);

    localparam int IDX_W  = $clog2(LINES);
    localparam int OFF_W  = $clog2(WORDS);
    localparam int BYTE_W = $clog2(DATA_W / 8);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W - BYTE_W;

    logic [TAG_W-1:0] a_tag;
    logic [IDX_W-1:0] a_idx;
    logic [OFF_W-1:0] a_off;
    logic [BYTE_W-1:0] a_byte;

    assign a_byte = cpu_addr[BYTE_W-1:0];
    assign a_off  = cpu_addr[BYTE_W +: OFF_W];
    assign a_idx  = cpu_addr[BYTE_W+OFF_W +: IDX_W];
    assign a_tag  = cpu_addr[ADDR_W-1 -: TAG_W];

    logic             lk_valid;
    logic             lk_dirty;
    logic [TAG_W-1:0] lk_tag;
    logic             fill_en;
    logic             wr_en;
    logic             set_dirty;
    logic             flush_inval;
    logic             victim_sel;
    logic             tag_match;

    assign tag_match = (lk_tag == a_tag);

    wbc_tag_store #(
        .LINES (LINES),
        .TAG_W (TAG_W)
    ) u_tags (
        .clk         (clk),
        .rst_n       (rst_n),
        .lk_idx      (a_idx),
        .fill_en     (fill_en),
        .fill_tag    (a_tag),
        .set_dirty   (set_dirty),
        .flush_inval (flush_inval),
        .lk_valid    (lk_valid),
        .lk_dirty    (lk_dirty),
        .lk_tag      (lk_tag)
    );

    wbc_data_store #(
        .LINES  (LINES),
        .WORDS  (WORDS),
        .DATA_W (DATA_W)
    ) u_data (
        .clk       (clk),
        .idx       (a_idx),
        .off       (a_off),
        .fill_en   (fill_en),
        .fill_line (mem_rline),
        .wr_en     (wr_en),
        .wr_data   (cpu_wdata),
        .rd_word   (cpu_rdata),
        .rd_line   (mem_wline)
    );

    wbc_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_rd      (cpu_rd),
        .cpu_wr      (cpu_wr),
        .cpu_flush   (cpu_flush),
        .lk_valid    (lk_valid),
        .lk_dirty    (lk_dirty),
        .tag_match   (tag_match),
        .mem_ready   (mem_ready),
        .cpu_stall   (cpu_stall),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .fill_en     (fill_en),
        .wr_en       (wr_en),
        .set_dirty   (set_dirty),
        .flush_inval (flush_inval),
        .victim_sel  (victim_sel)
    );

    // Write-back goes to the victim's own line; the fill goes to the request's line.
    logic unused_byte;
    assign unused_byte = ^a_byte;

    assign mem_addr = {(victim_sel ? lk_tag : a_tag), a_idx, {(OFF_W + BYTE_W){1'b0}}} | {{(ADDR_W-1){1'b0}}, unused_byte & 1'b0};

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))) else $error("memory request changed before ready"); // R10

endmodule

// File: tb/test_wb_cache_flush.sv
module test_wb_cache_flush;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [31:0]  cpu_addr = '0;
    logic         cpu_rd = 1'b0;
    logic         cpu_wr = 1'b0;
    logic [31:0]  cpu_wdata = '0;
    logic         cpu_flush = 1'b0;
    logic [31:0]  cpu_rdata;
    logic         cpu_stall;
    logic         mem_req;
    logic         mem_we;
    logic [31:0]  mem_addr;
    logic [127:0] mem_wline;
    logic [127:0] mem_rline;
    logic         mem_ready = 1'b0;

    always #10 clk = ~clk;

    wb_cache_flush i_wb_cache_flush (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_flush(cpu_flush), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wline(mem_wline),
        .mem_rline(mem_rline), .mem_ready(mem_ready)
    );

    logic [31:0] mem  [1024];
    logic [31:0] gold [1024];
    int n_chk = 0;
    int n_fail = 0;
    int n_txn = 0;
    int n_wtxn = 0;
    bit done = 0;

    // Memory model: whole-line transfers on req && ready edges.
    assign mem_rline = {mem[{mem_addr[11:4], 2'd3}], mem[{mem_addr[11:4], 2'd2}],
                        mem[{mem_addr[11:4], 2'd1}], mem[{mem_addr[11:4], 2'd0}]};

    always @(posedge clk) begin
        if (mem_req && mem_ready) begin
            n_txn <= n_txn + 1;
            if (mem_addr[3:0] != 4'd0) begin
                n_fail <= n_fail + 1;
                $display("FAIL R10: mem_addr low bits actual %h expected 0", mem_addr[3:0]);
            end
            if (mem_we) begin
                n_wtxn <= n_wtxn + 1;
                for (int w = 0; w < 4; w++) mem[{mem_addr[11:4], w[1:0]}] <= mem_wline[w*32 +: 32];
            end
        end
    end

    initial begin
        int lat;
        lat = 0;
        forever begin
            @(negedge clk);
            if (mem_ready) begin
                mem_ready = 1'b0;
                lat = $urandom % 3;
            end else if (mem_req) begin
                if (lat == 0) mem_ready = 1'b1;
                else lat--;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int widx(input logic [31:0] a);
        return int'(a[11:2]);
    endfunction

    task automatic access(input logic wr, input logic [31:0] a, input logic [31:0] d,
                          output logic [31:0] rdata, output int stalls);
        @(negedge clk);
        cpu_addr = a; cpu_rd = !wr; cpu_wr = wr; cpu_wdata = d;
        stalls = 0;
        #2;
        while (cpu_stall) begin
            stalls++;
            @(negedge clk);
            #2;
        end
        rdata = cpu_rdata;
        @(posedge clk);
        #1;
        cpu_rd = 1'b0; cpu_wr = 1'b0;
        if (wr) gold[widx(a)] = d;
    endtask

    task automatic flush(input logic [31:0] a, input logic with_wr, input logic [31:0] d);
        int t0;
        @(negedge clk);
        cpu_addr = a; cpu_flush = 1'b1; cpu_wr = with_wr; cpu_wdata = d;
        t0 = n_txn;
        #2;
        chk("R8 flush stall", {31'd0, cpu_stall}, 32'd0);
        @(posedge clk);
        #1;
        cpu_flush = 1'b0; cpu_wr = 1'b0;
        @(negedge clk);
        chk("R8 flush mem_req", {31'd0, mem_req}, 32'd0);
        chk("R8 flush txn", n_txn, t0);
    endtask

    task automatic dma_line(input logic [31:0] a);
        for (int w = 0; w < 4; w++) begin
            logic [31:0] v;
            v = $urandom;
            mem[{a[11:4], w[1:0]}] = v;
            gold[{a[11:4], w[1:0]}] = v;
        end
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int st;
        int t0;
        int w0;
        void'($urandom(32'd7177));
        for (int i = 0; i < 1024; i++) begin
            mem[i] = (i * 32'h01010101) ^ 32'hA500_0000;
            gold[i] = mem[i];
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 stall after reset", {31'd0, cpu_stall}, 32'd0);
        chk("R1 mem_req after reset", {31'd0, mem_req}, 32'd0);

        // R1/R3: first read misses with one line read
        t0 = n_txn;
        access(1'b0, 32'h040, 0, rd, st);
        chk("R1 first read misses", {31'd0, st > 0}, 32'd1);
        chk("R3 miss data", rd, gold[widx(32'h040)]);
        chk("R3 one fill", n_txn - t0, 1);

        // R2: hit
        t0 = n_txn;
        access(1'b0, 32'h044, 0, rd, st);
        chk("R2 hit no stall", st, 0);
        chk("R2 hit data", rd, gold[widx(32'h044)]);
        chk("R2 hit no txn", n_txn, t0);

        // R4: write hit, then dirty eviction
        t0 = n_txn;
        access(1'b1, 32'h048, 32'hDEAD_0001, rd, st);
        chk("R4 write hit no txn", n_txn, t0);
        access(1'b0, 32'h048, 0, rd, st);
        chk("R4 write hit readback", rd, 32'hDEAD_0001);
        chk("R4 memory not yet written", mem[widx(32'h048)], (widx(32'h048) * 32'h01010101) ^ 32'hA500_0000);
        t0 = n_txn; w0 = n_wtxn;
        access(1'b0, 32'h148, 0, rd, st);
        chk("R4 eviction two txns", n_txn - t0, 2);
        chk("R4 one writeback", n_wtxn - w0, 1);
        chk("R4 writeback data", mem[widx(32'h048)], 32'hDEAD_0001);
        chk("R4 new line data", rd, gold[widx(32'h148)]);

        // R5/R6: dirty line flushed after DMA overwrite
        access(1'b1, 32'h248, 32'hBAD0_BAD0, rd, st);
        dma_line(32'h240);
        flush(32'h24C, 1'b0, 0);
        t0 = n_txn; w0 = n_wtxn;
        access(1'b0, 32'h248, 0, rd, st);
        chk("R5 refetch after flush", rd, gold[widx(32'h248)]);
        chk("R5 read misses", {31'd0, st > 0}, 32'd1);
        chk("R6 no writeback", n_wtxn - w0, 0);
        chk("R6 memory keeps DMA value", mem[widx(32'h248)], gold[widx(32'h248)]);

        // R7: non-matching flush leaves dirty line intact
        access(1'b1, 32'h348, 32'h0123_4567, rd, st);
        flush(32'h048, 1'b0, 0);
        access(1'b0, 32'h348, 0, rd, st);
        chk("R7 still hit", st, 0);
        chk("R7 dirty data kept", rd, 32'h0123_4567);
        t0 = n_wtxn;
        access(1'b0, 32'h448, 0, rd, st);
        chk("R7 dirty still written back", n_wtxn - t0, 1);
        chk("R7 written back value", mem[widx(32'h348)], 32'h0123_4567);

        // R9: flush with simultaneous write
        access(1'b0, 32'h540, 0, rd, st);
        dma_line(32'h540);
        flush(32'h548, 1'b1, 32'hFFFF_0000);
        access(1'b0, 32'h548, 0, rd, st);
        chk("R9 write discarded", rd, gold[widx(32'h548)]);
        chk("R9 line invalidated", {31'd0, st > 0}, 32'd1);

        // Random phase
        for (int k = 0; k < 1500; k++) begin
            int op;
            logic [31:0] a;
            logic [31:0] d;
            op = $urandom % 100;
            a = ($urandom % 4096) & 32'hFFC;
            d = $urandom;
            if (op < 45) begin
                access(1'b0, a, 0, rd, st);
                chk("R3 random read", rd, gold[widx(a)]);
            end else if (op < 85) begin
                access(1'b1, a, d, rd, st);
            end else begin
                dma_line(a);
                flush(a, 1'b0, 0);
            end
        end
        for (int k = 0; k < 64; k++) begin
            logic [31:0] a;
            a = k * 64;
            access(1'b0, a, 0, rd, st);
            chk("R4 final sweep", rd, gold[widx(a)]);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule